// File: doc/BRIEF.md
# Phase-Accumulator PWM Channel with Latched Updates

This block drives one pulse-width-modulated output from a single 32-bit control word. Every clock, a programmable increment is added to an N-bit phase accumulator that wraps modulo 2^N. The increment therefore sets the output frequency: f_out = increment x f_clk / 2^N. The top eight bits of the accumulator form a phase byte. That byte is compared with an 8-bit threshold to set the duty cycle. The threshold is inverted, so a larger value gives a shorter high time. Software derives it as 255 - 255 x duty / period.

Writes go into a pending copy of the increment and the threshold. The comparator and accumulator use a separate running copy. That copy is reloaded only when software sets the update-request bit. The hardware clears the bit itself once the transfer is done. While the channel runs, the transfer waits for the next accumulator wrap, so a period is never cut short. While the channel is stopped, the transfer happens at once. The channel can only be started after at least one such transfer, so the running copy always holds real values. Reads return the pending fields together with the live enable and update-request state. A saved word can therefore be written back to restore the channel.

Top module: `pwm_acc_top`

## Requirements
- R1: After reset the read word is all zeros and the output is low.
- R2: The enable bit (bit 31) can be set only after at least one transfer of the running copy has completed. A write that sets bit 31 before that leaves the enable bit reading 0 and the output low. Clearing the enable bit is always accepted.
- R3: Layout of the control word: bits 7:0 hold the threshold, and bits 8 to 8+BU_W-1 hold the increment. Bit 30 is the update request and bit 31 is the enable. A read returns the last written threshold and increment. Any bit between the increment field and bit 30 reads 0.
- R4: Writing 1 to bit 30 sets the update request. Writing 0 to bit 30 does not clear it. While the channel is disabled, the request completes on the next clock, and bit 30 then reads 0.
- R5: While the channel is enabled, written threshold or increment values do not change the output until an update request is made. The request is completed at the next accumulator wrap, after which bit 30 reads 0 and the new values drive the output.
- R6: The output period is 2^BU_W / increment clock cycles, with one rising edge per period (increment 256 gives 256 cycles, increment 1024 gives 64 cycles, for BU_W = 16).
- R7: The output is high while the phase byte (accumulator bits BU_W-1 to BU_W-8) is strictly greater than the running threshold. With increment 256 and BU_W = 16, threshold T gives 255 - T high cycles out of every 256.
- R8: While the enable bit is 0 the output is held low and the accumulator is held at zero.
- R9: A word read back from the block and written again, with the enable bit set, restarts the channel with its previous running settings. No new update request is needed once a transfer has happened since reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Pending fields plus live enable and update-request bits |
| pwm_out | output | 1 | PWM output |

## Verification
The bench tries to start the channel before any update. A design that skips the start gate would toggle the output from a running copy that was never loaded. It rewrites the threshold on a running channel without a request. A design that fails to isolate the pending copy would change the duty at once. It then requests an update and expects the request bit to stay set until the wrap and clear afterwards. A design that never clears the bit, or that loads in the middle of a period, would show up here. Duty is counted over whole periods at both extremes of the inverted threshold and at the midpoint, which exposes an off-by-one or a non-inverted compare. Edge counts at two increments expose a wrong accumulator width or a wrong wrap. Finally the bench stops the channel and writes the saved word back. A design that drops its running copy or its start permission on disable would stay silent after the write-back.

// File: rtl/pwm_acc_pkg.sv
package pwm_acc_pkg;
    localparam int CTRL_W    = 32;
    localparam int EN_BIT    = 31;
    localparam int UPD_BIT   = 30;
    localparam int INC_LSB   = 8;
    localparam int PHASE_W   = 8;
    localparam int MAX_INC_W = UPD_BIT - INC_LSB;
endpackage

// File: rtl/pwm_acc_regs.sv
module pwm_acc_regs
    import pwm_acc_pkg::*;
#(
    parameter int BU_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en_i,
    input  logic [CTRL_W-1:0]   wr_data_i,
    input  logic                load_i,
    output logic [PHASE_W-1:0]  pend_thr_o,
    output logic [BU_W-1:0]     pend_inc_o,
    output logic                en_o,
    output logic                upd_o,
    output logic                primed_o,
    output logic [CTRL_W-1:0]   rd_data_o
);
    localparam int SPARE_W = MAX_INC_W - BU_W;

    typedef struct packed {
        logic [PHASE_W-1:0] thr;
        logic [BU_W-1:0]    inc;
        logic               en;
        logic               upd;
        logic               primed;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (load_i) begin
            regs_d.upd    = 1'b0;
            regs_d.primed = 1'b1;
        end
        if (wr_en_i) begin
            regs_d.thr = wr_data_i[PHASE_W-1:0];
            regs_d.inc = wr_data_i[INC_LSB +: BU_W];
            regs_d.en  = wr_data_i[EN_BIT] & regs_q.primed;
            if (wr_data_i[UPD_BIT]) begin
                regs_d.upd = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    generate
        if (SPARE_W > 0) begin : g_spare
            assign rd_data_o = {regs_q.en, regs_q.upd, {SPARE_W{1'b0}},
                                regs_q.inc, regs_q.thr};
        end else begin : g_full
            assign rd_data_o = {regs_q.en, regs_q.upd, regs_q.inc, regs_q.thr};
        end
    endgenerate

    assign pend_thr_o = regs_q.thr;
    assign pend_inc_o = regs_q.inc;
    assign en_o       = regs_q.en;
    assign upd_o      = regs_q.upd;
    assign primed_o   = regs_q.primed;
endmodule

// File: rtl/pwm_acc_shadow.sv
module pwm_acc_shadow
    import pwm_acc_pkg::*;
#(
    parameter int BU_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_i,
    input  logic               upd_i,
    input  logic               wrap_i,
    input  logic [PHASE_W-1:0] pend_thr_i,
    input  logic [BU_W-1:0]    pend_inc_i,
    output logic [PHASE_W-1:0] run_thr_o,
    output logic [BU_W-1:0]    run_inc_o,
    output logic               load_o
);
    typedef struct packed {
        logic [PHASE_W-1:0] thr;
        logic [BU_W-1:0]    inc;
    } run_t;

    run_t run_d, run_q;
    logic load;

    always_comb begin
        load  = upd_i & (~en_i | wrap_i);
        run_d = run_q;
        if (load) begin
            run_d.thr = pend_thr_i;
            run_d.inc = pend_inc_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else begin
            run_q <= run_d;
        end
    end

    assign run_thr_o = run_q.thr;
    assign run_inc_o = run_q.inc;
    assign load_o    = load;
endmodule

// File: rtl/pwm_acc_phase.sv
module pwm_acc_phase
    import pwm_acc_pkg::*;
#(
    parameter int BU_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_i,
    input  logic [BU_W-1:0]    inc_i,
    output logic [PHASE_W-1:0] phase_o,
    output logic               wrap_o
);
    typedef struct packed {
        logic [BU_W-1:0] acc;
    } acc_t;

    acc_t acc_d, acc_q;
    logic [BU_W:0] sum;

    always_comb begin
        sum    = {1'b0, acc_q.acc} + {1'b0, inc_i};
        wrap_o = run_i & sum[BU_W];
        acc_d  = acc_q;
        if (run_i) begin
            acc_d.acc = sum[BU_W-1:0];
        end else begin
            acc_d.acc = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign phase_o = acc_q.acc[BU_W-1 -: PHASE_W];
endmodule

// File: rtl/pwm_acc_cmp.sv
module pwm_acc_cmp
    import pwm_acc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_i,
    input  logic [PHASE_W-1:0] phase_i,
    input  logic [PHASE_W-1:0] thr_i,
    output logic               pwm_o
);
    typedef struct packed {
        logic level;
    } out_t;

    out_t out_d, out_q;

    always_comb begin
        out_d       = out_q;
        out_d.level = en_i & (phase_i > thr_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign pwm_o = out_q.level;
endmodule

// File: rtl/pwm_acc_top.sv
module pwm_acc_top
    import pwm_acc_pkg::*;
#(
    parameter int BU_W = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    output logic        pwm_out
);
    logic [PHASE_W-1:0] pend_thr;
    logic [BU_W-1:0]    pend_inc;
    logic [PHASE_W-1:0] run_thr;
    logic [BU_W-1:0]    run_inc;
    logic [PHASE_W-1:0] phase;
    logic               ctl_en;
    logic               ctl_upd;
    logic               primed;
    logic               load;
    logic               wrap;

    pwm_acc_regs #(.BU_W(BU_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en),
        .wr_data_i  (wr_data),
        .load_i     (load),
        .pend_thr_o (pend_thr),
        .pend_inc_o (pend_inc),
        .en_o       (ctl_en),
        .upd_o      (ctl_upd),
        .primed_o   (primed),
        .rd_data_o  (rd_data)
    );

    pwm_acc_shadow #(.BU_W(BU_W)) u_shadow (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (ctl_en),
        .upd_i      (ctl_upd),
        .wrap_i     (wrap),
        .pend_thr_i (pend_thr),
        .pend_inc_i (pend_inc),
        .run_thr_o  (run_thr),
        .run_inc_o  (run_inc),
        .load_o     (load)
    );

    pwm_acc_phase #(.BU_W(BU_W)) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (ctl_en),
        .inc_i   (run_inc),
        .phase_o (phase),
        .wrap_o  (wrap)
    );

    pwm_acc_cmp u_cmp (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (ctl_en),
        .phase_i (phase),
        .thr_i   (run_thr),
        .pwm_o   (pwm_out)
    );
endmodule

// File: rtl/pwm_acc_chk.sv
module pwm_acc_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [31:0] wr_data,
    input logic [31:0] rd_data,
    input logic        pwm_out,
    input logic        en_q,
    input logic        upd_q,
    input logic        primed_q,
    input logic [7:0]  run_thr
);
    // R2
    enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !primed_q |=> !en_q);

    // R3
    thr_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_data[7:0] == $past(wr_data[7:0]));

    // R4
    idle_update_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_q && !en_q && !(wr_en && wr_data[30])) |=> !rd_data[30]);

    // R5
    running_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_q |=> $stable(run_thr));

    // R8
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> !pwm_out);
endmodule

bind pwm_acc_top pwm_acc_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .pwm_out  (pwm_out),
    .en_q     (ctl_en),
    .upd_q    (ctl_upd),
    .primed_q (primed),
    .run_thr  (run_thr)
);

// File: tb/pwm_acc_top_test.sv
module pwm_acc_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        pwm_out;
    int          checks = 0;
    int          errors = 0;
    logic [31:0] saved;

    localparam logic [31:0] EN  = 32'h8000_0000;
    localparam logic [31:0] UPD = 32'h4000_0000;

    always #10 clk = ~clk;

    pwm_acc_top #(.BU_W(16)) uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .pwm_out (pwm_out)
    );

    function automatic logic [31:0] word(input int inc, input int thr);
        return (32'(inc) << 8) | 32'(thr);
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic write(input logic [31:0] v);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic count_high(input int n, output int hi, output int rises);
        logic prev;
        hi = 0;
        rises = 0;
        prev = pwm_out;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_out) hi++;
            if (pwm_out && !prev) rises++;
            prev = pwm_out;
        end
    endtask

    task automatic wait_update_done(input string req);
        int n = 0;
        while (rd_data[30] && n < 2000) begin
            @(negedge clk);
            n++;
        end
        check(req, "update bit cleared", int'(rd_data[30]), 0);
    endtask

    task automatic t_reset;
        check("R1", "read word after reset", int'(rd_data), 0);
        check("R1", "output after reset", int'(pwm_out), 0);
    endtask

    task automatic t_enable_gate;
        int hi, r;
        write(EN | word(256, 127));
        check("R2", "enable bit before any update", int'(rd_data[31]), 0);
        count_high(300, hi, r);
        check("R2", "output high cycles before any update", hi, 0);
    endtask

    task automatic t_layout;
        write(32'h3F00_0000 | word(16'hABCD, 8'h5A));
        check("R3", "spare bits read zero, fields read back", int'(rd_data), int'(32'h00AB_CD5A));
        write('0);
    endtask

    task automatic t_idle_update;
        write(UPD | word(256, 127));
        check("R4", "request visible right after write", int'(rd_data[30]), 1);
        @(negedge clk);
        check("R4", "word after idle transfer", int'(rd_data), int'(word(256, 127)));
        write(word(256, 127));
        check("R4", "writing 0 to bit 30 leaves it clear", int'(rd_data[30]), 0);
    endtask

    task automatic t_run_mid;
        int hi, r;
        write(EN | word(256, 127));
        check("R2", "enable accepted after update", int'(rd_data[31]), 1);
        idle(20);
        count_high(1024, hi, r);
        check("R7", "high cycles in 1024, threshold 127", hi, 512);
        check("R6", "rising edges in 1024, increment 256", r, 4);
    endtask

    task automatic t_latching;
        int hi, r;
        write(EN | word(256, 0));
        check("R5", "pending threshold reads back", int'(rd_data[7:0]), 0);
        idle(20);
        count_high(256, hi, r);
        check("R5", "duty unchanged without request", hi, 128);
        write(EN | UPD | word(256, 0));
        check("R5", "request held while running", int'(rd_data[30]), 1);
        wait_update_done("R5");
        idle(5);
        count_high(256, hi, r);
        check("R7", "high cycles, threshold 0", hi, 255);
    endtask

    task automatic t_freq;
        int hi, r;
        write(EN | UPD | word(1024, 127));
        wait_update_done("R6");
        idle(5);
        count_high(1024, hi, r);
        check("R6", "rising edges in 1024, increment 1024", r, 16);
        check("R7", "high cycles in 1024, increment 1024", hi, 512);
    endtask

    task automatic t_extremes;
        int hi, r;
        write(EN | UPD | word(256, 255));
        wait_update_done("R7");
        idle(5);
        count_high(256, hi, r);
        check("R7", "high cycles, threshold 255", hi, 0);
        write(EN | UPD | word(256, 63));
        wait_update_done("R7");
        idle(5);
        count_high(256, hi, r);
        check("R7", "high cycles, threshold 63", hi, 192);
    endtask

    task automatic t_disable_restore;
        int hi, r;
        saved = rd_data;
        write(saved & ~EN);
        check("R8", "enable bit after clear", int'(rd_data[31]), 0);
        check("R9", "fields kept after disable", int'(rd_data), int'(word(256, 63)));
        count_high(300, hi, r);
        check("R8", "high cycles while disabled", hi, 0);
        write(saved);
        check("R9", "enable accepted on write-back", int'(rd_data[31]), 1);
        idle(20);
        count_high(256, hi, r);
        check("R9", "duty after write-back", hi, 192);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_enable_gate();
        t_layout();
        t_idle_update();
        t_run_mid();
        t_latching();
        t_freq();
        t_extremes();
        t_disable_restore();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule